// File: doc/BRIEF.md
# Executed-Address Trace Buffer

This block keeps a short history of where the processor has just been. In normal run mode, every instruction-completion strobe stores the program address of that instruction in a five-slot ring. The newest address always replaces the oldest. A debug controller can later find out which instructions ran just before the core stopped.

When the debug-mode flag is raised, capture freezes and the ring becomes read-only. All five slots share one read strobe; there is no per-slot address. On the first debug cycle the read position is set to the oldest of the five stored addresses. Each read strobe returns one address on a registered output and moves the read position forward by one. Five reads therefore give the history in execution order, and the position ends where it began. Reads do not remove data, so the same history can be walked again.

Top module: `exec_trace_buf`

## Requirements
- R1: In run mode (`dbg_mode` = 0), each cycle with `exec_vld` = 1 stores `exec_addr` in the slot at the write position, and the write position then advances modulo 5. After more than five strobes, only the latest five addresses remain.
- R2: On the first cycle with `dbg_mode` = 1, the read position selects the slot that holds the oldest of the last five recorded addresses.
- R3: In debug mode, a read strobe (`rd_req` = 1) sampled at a clock edge places the selected slot's address on `rd_data` after that same edge. Successive reads return addresses from oldest to newest.
- R4: Each debug read advances the read position by one, wrapping modulo 5. After five reads the position is back at its starting slot, so a sixth read returns the oldest address again.
- R5: While `dbg_mode` = 1, `exec_vld` strobes change neither the stored addresses nor the write position.
- R6: While `dbg_mode` = 0, `rd_req` is ignored: `rd_data` keeps its value, and the next debug session still starts at the oldest slot.
- R7: A synchronous active-high `rst` clears `rd_data` to zero, empties all five slots and sets both positions to slot 0. A slot not written since reset reads as zero, in its normal rotation place.
- R8: `rd_data` changes only on a debug read and holds its value in every other cycle.
- R9: Leaving debug mode resumes capture at the frozen write position. A later debug entry starts at the oldest slot again, even if the previous session stopped partway through the five reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_vld | input | 1 | An instruction completed this cycle |
| exec_addr | input | AW (16) | Program address of the completed instruction |
| dbg_mode | input | 1 | High while the core is halted in debug mode |
| rd_req | input | 1 | Read one history entry (honoured in debug mode only) |
| rd_data | output | AW (16) | Registered history entry returned by the last read |

## Verification
Capture has a one-edge latency: a strobe sampled at edge k is visible to a read issued at any later edge. A debug read sampled at edge k updates `rd_data` right after edge k. The bench drives all inputs just after a falling edge and compares `rd_data` against its reference model at the next falling edge. That is half a period after the single register stage, so every comparison lands in the cycle the result is due. The bench also checks `rd_data` in every cycle that has no read, which covers the hold rule and the ignored-read rule at the same sampling point.

// File: rtl/trace_pkg.sv
`timescale 1ns/1ps
package trace_pkg;

  // Advance a ring position by one, wrapping at depth.
  function automatic int unsigned ring_next(input int unsigned pos,
                                            input int unsigned depth);
    return (pos + 1 >= depth) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/trace_ring_ptr.sv
`timescale 1ns/1ps
// Modulo-DEPTH position register with a load that takes priority over an increment.
module trace_ring_ptr #(
  parameter int DEPTH = 5,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          load,
  input  logic [PW-1:0] load_val,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] pos_nxt
);
  import trace_pkg::*;

  logic [PW-1:0] pos_inc;

  always_comb begin
    pos_inc = PW'(ring_next(32'(pos), DEPTH));
    if (load)     pos_nxt = load_val;
    else if (inc) pos_nxt = pos_inc;
    else          pos_nxt = pos;
  end

  always_ff @(posedge clk) begin
    if (rst) pos <= '0;
    else     pos <= pos_nxt;
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    32'(pos) < DEPTH);  // R4

  AST_POS_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !load && 32'(pos) == DEPTH - 1) |=> (pos == '0));  // R4

endmodule

// File: rtl/trace_store.sv
`timescale 1ns/1ps
// History storage: plain array without reset (RAM-style), per-slot filled flags
// that do reset, and one registered read port.
module trace_store #(
  parameter int DEPTH = 5,
  parameter int AW    = 16,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [AW-1:0] wdata,
  input  logic          re,
  input  logic [PW-1:0] raddr,
  output logic [AW-1:0] rdata
);

  logic [AW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] filled;

  // Storage write: no reset, so a RAM can be inferred.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Filled flags make unwritten slots read as zero after reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      filled <= '0;
    end else if (we) begin
      filled[waddr] <= 1'b1;
    end
  end

  // Registered read port; writes and reads never overlap (run vs debug mode).
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= filled[raddr] ? mem[raddr] : '0;
    end
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !re |=> $stable(rdata));  // R8

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(we && re));  // R5

endmodule

// File: rtl/exec_trace_buf.sv
`timescale 1ns/1ps
module exec_trace_buf #(
  parameter int DEPTH = 5,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec_vld,
  input  logic [AW-1:0] exec_addr,
  input  logic          dbg_mode,
  input  logic          rd_req,
  output logic [AW-1:0] rd_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic          cap_en;
  logic          rd_en;
  logic [PW-1:0] wr_pos, wr_pos_nxt;
  logic [PW-1:0] rd_pos, rd_pos_nxt;

  // Capture only in run mode; reads only in debug mode.
  assign cap_en = exec_vld & ~dbg_mode;
  assign rd_en  = rd_req & dbg_mode;

  // Write position: advances on each captured address.
  trace_ring_ptr #(.DEPTH(DEPTH)) u_wr_ptr (
    .clk     (clk),
    .rst     (rst),
    .inc     (cap_en),
    .load    (1'b0),
    .load_val('0),
    .pos     (wr_pos),
    .pos_nxt (wr_pos_nxt)
  );

  // Read position: follows the write position in run mode, so it rests on
  // the oldest slot when debug mode starts; steps on each debug read.
  trace_ring_ptr #(.DEPTH(DEPTH)) u_rd_ptr (
    .clk     (clk),
    .rst     (rst),
    .inc     (rd_en),
    .load    (~dbg_mode),
    .load_val(wr_pos_nxt),
    .pos     (rd_pos),
    .pos_nxt (rd_pos_nxt)
  );

  trace_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk  (clk),
    .rst  (rst),
    .we   (cap_en),
    .waddr(wr_pos),
    .wdata(exec_addr),
    .re   (rd_en),
    .raddr(rd_pos),
    .rdata(rd_data)
  );

  AST_FROZEN_IN_DEBUG: assert property (@(posedge clk) disable iff (rst)
    dbg_mode |=> $stable(wr_pos));  // R5

  AST_ENTRY_AT_OLDEST: assert property (@(posedge clk) disable iff (rst)
    $rose(dbg_mode) |-> (rd_pos == wr_pos));  // R2

  AST_RUN_TRACKS_WRITE: assert property (@(posedge clk) disable iff (rst)
    !dbg_mode |=> (rd_pos == wr_pos));  // R9

  AST_RUN_READ_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!dbg_mode && rd_req) |=> $stable(rd_data));  // R6

endmodule

// File: tb/exec_trace_buf_tb.sv
`timescale 1ns/1ps
module exec_trace_buf_tb;
  localparam int AW = 16;
  localparam int D  = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          exec_vld = 1'b0;
  logic [AW-1:0] exec_addr = '0;
  logic          dbg_mode = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_data;

  int errors = 0;
  int checks = 0;

  // Reference model built from the requirements.
  logic [AW-1:0] m_mem [D];
  int            m_wp = 0;
  int            m_rp = 0;
  logic [AW-1:0] exp_rd = '0;

  always #4 clk = ~clk;  // 125 MHz

  exec_trace_buf #(.DEPTH(D), .AW(AW)) u_dut (
    .clk(clk), .rst(rst), .exec_vld(exec_vld), .exec_addr(exec_addr),
    .dbg_mode(dbg_mode), .rd_req(rd_req), .rd_data(rd_data)
  );

  function automatic int wrap5(input int p);
    return (p + 1) % D;
  endfunction

  task automatic check(input logic [AW-1:0] act, input logic [AW-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive after a falling edge, let the rising edge act, sample at the next falling edge.
  task automatic cyc(input logic v, input logic [AW-1:0] a, input logic d,
                     input logic r, input string rd_tag);
    string tag;
    exec_vld = v; exec_addr = a; dbg_mode = d; rd_req = r;
    if (!d) begin
      if (v) begin m_mem[m_wp] = a; m_wp = wrap5(m_wp); end
      m_rp = m_wp;
    end else if (r) begin
      exp_rd = m_mem[m_rp];
      m_rp = wrap5(m_rp);
    end
    tag = (d && r) ? rd_tag : (r ? "R6" : (d && v) ? "R5" : "R8");
    @(posedge clk);
    @(negedge clk);
    check(rd_data, exp_rd, tag);
  endtask

  task automatic run_exec(input logic [AW-1:0] a);
    cyc(1'b1, a, 1'b0, 1'b0, "R1");
  endtask

  task automatic dbg_read(input string tag);
    cyc(1'b0, '0, 1'b1, 1'b1, tag);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < D; i++) m_mem[i] = '0;
    void'($urandom(32'd20240611));

    // R7: reset state
    @(negedge clk); @(negedge clk); @(negedge clk);
    check(rd_data, '0, "R7");
    rst = 1'b0;

    // R7: empty buffer reads zero through a full pass
    for (int i = 0; i < D; i++) dbg_read("R7");

    // R7/R4: two addresses, then zeros in rotation order, sixth read wraps
    cyc(1'b0, '0, 1'b0, 1'b0, "R8");
    run_exec(16'hA001);
    run_exec(16'hB002);
    for (int i = 0; i < D; i++) dbg_read("R7");
    dbg_read("R4");

    // R1/R3: seven writes keep only the last five, read oldest first
    cyc(1'b0, '0, 1'b0, 1'b1, "R6");
    for (int i = 1; i <= 7; i++) run_exec(AW'(16'h1000 + i));
    for (int i = 0; i < D; i++) dbg_read("R3");
    dbg_read("R4");

    // R5: strobes during debug are ignored
    for (int i = 0; i < 3; i++) cyc(1'b1, 16'hDEAD, 1'b1, 1'b0, "R5");
    for (int i = 0; i < D; i++) dbg_read("R5");

    // R9: partial session, resume capture, re-entry starts at oldest
    cyc(1'b0, '0, 1'b0, 1'b0, "R8");
    run_exec(16'hC0DE);
    for (int i = 0; i < 2; i++) dbg_read("R9");
    cyc(1'b0, '0, 1'b0, 1'b0, "R8");
    run_exec(16'hC0DF);
    for (int i = 0; i < D; i++) dbg_read("R9");

    // Random mixed sessions
    for (int round = 0; round < 60; round++) begin
      int nrun;
      int ndbg;
      nrun = int'($urandom_range(0, 12));
      ndbg = int'($urandom_range(1, 14));
      for (int i = 0; i < nrun; i++)
        cyc(($urandom_range(0, 3) != 0), AW'($urandom), 1'b0,
            ($urandom_range(0, 3) == 0), "R6");
      for (int i = 0; i < ndbg; i++)
        cyc(($urandom_range(0, 2) == 0), AW'($urandom), 1'b1,
            ($urandom_range(0, 1) == 1), "R3");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule